// File: doc/BRIEF.md
# Rotating Priority Interrupt Resolver

This block decides which of eight interrupt lines, if any, should be presented to the processor. It takes a request vector, a mask vector and an in-service vector, together with a rotation offset that sets which line currently holds top priority. It returns a valid flag and the number of the winning line. The block is purely combinational and holds no state. Storage of the three vectors and decoding of commands sit in the surrounding controller.

Priority is measured as a rank counted from the rotation offset. The line equal to the offset has rank 0, the next line upward has rank 1, and the count wraps past line 7. The best unmasked request is compared against the best line already in service, and only a strictly better rank preempts. When the resolver serves as the master of a cascaded pair and special fully nested mode is enabled, the cascade input line (line 2) is left out of the in-service comparison. This allows a slave's higher-priority request to pass through while an earlier slave interrupt is still being serviced.

Top module: `rpr_resolver`

## Requirements
- R1: Rank k belongs to line (rot_offset + k) mod 8. Among unmasked requests, the one with the lowest rank wins.
- R2: A request bit whose mask bit is 1 never takes part in arbitration and is never reported.
- R3: When no request bit is unmasked, irq_valid is 0 and irq_line is 0.
- R4: When the in-service vector is all zeros (after any exclusion), any unmasked request asserts irq_valid.
- R5: irq_valid is 1 only when the best candidate rank is strictly lower than the best in-service rank. A request on a line that is itself the best in-service line, or that has a worse rank, does not assert irq_valid.
- R6: With sfnm_en=1 and is_master=1, in-service bit 2 is ignored when the current rank is computed.
- R7: sfnm_en has no effect when is_master=0, and is_master has no effect when sfnm_en=0.
- R8: When irq_valid is 1, irq_line equals (candidate rank + rot_offset) mod 8, and that line's request bit is set and unmasked.
- R9: Only the best-ranked in-service bit matters. Adding in-service bits of worse rank than the current best leaves both outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| req_vec | input | 8 | Pending request per line |
| mask_vec | input | 8 | 1 blocks the matching request |
| isr_vec | input | 8 | Lines currently in service |
| rot_offset | input | 3 | Line that holds rank 0 |
| sfnm_en | input | 1 | Special fully nested mode enable |
| is_master | input | 1 | This resolver is the cascade master |
| irq_valid | output | 1 | An interrupt should be raised |
| irq_line | output | 3 | Winning line number, 0 when not valid |

## Verification
The embedded checks assume that all inputs settle to known, two-valued levels before they are evaluated. They also assume that the in-service vector may hold several bits at once, as it does when interrupts nest. The bench changes inputs only just after a rising edge and compares the outputs at the falling edge, so every comparison sees settled values. Random vectors include in-service vectors with several bits set, requests that coincide with in-service lines, and every combination of the two mode flags. This covers the exclusion path and the equal-rank case without ever driving an undefined level.

// File: rtl/rpr_pkg.sv
// Package: shared helpers for the rotating priority resolver.
// Assumes line counts are small positive integers.
package rpr_pkg;

    // Width of a rank value able to hold 0..n (n means "none").
    function automatic int unsigned rank_width(input int unsigned n);
        return $clog2(n + 1);
    endfunction

endpackage

// File: rtl/rpr_rotator.sv
// Module: rpr_rotator
// Reorders a line vector into rank order: output bit r is the input bit of
// line (offset + r) mod N_LINES. Assumes offset < N_LINES.
module rpr_rotator #(
    parameter int N_LINES = 8,
    parameter int IDX_W   = $clog2(N_LINES)
) (
    input  logic [N_LINES-1:0] vec_in,
    input  logic [IDX_W-1:0]   offset,
    output logic [N_LINES-1:0] vec_out
);
    localparam logic [IDX_W:0] LIMIT = (IDX_W+1)'(N_LINES);

    for (genvar r = 0; r < N_LINES; r++) begin : g_rank
        logic [IDX_W:0]   sum;
        logic [IDX_W:0]   wrapped;
        logic [IDX_W-1:0] src;
        // Source line for rank r, wrapped into range.
        always_comb begin
            sum     = {1'b0, offset} + (IDX_W+1)'(r);
            wrapped = (sum >= LIMIT) ? (sum - LIMIT) : sum;
            src     = wrapped[IDX_W-1:0];
        end
        assign vec_out[r] = vec_in[src];
    end
endmodule

// File: rtl/rpr_rank_finder.sv
// Module: rpr_rank_finder
// Returns the index of the lowest set bit of a rank-ordered vector, or
// N_LINES when the vector is empty.
module rpr_rank_finder #(
    parameter int N_LINES = 8,
    parameter int RANK_W  = rpr_pkg::rank_width(N_LINES)
) (
    input  logic [N_LINES-1:0] ranked,
    output logic [RANK_W-1:0]  best_rank
);
    // Scan from the worst rank down so the best set bit wins last.
    always_comb begin
        best_rank = RANK_W'(N_LINES);
        for (int i = N_LINES - 1; i >= 0; i--) begin
            if (ranked[i]) best_rank = RANK_W'(i);
        end
    end
endmodule

// File: rtl/rpr_decider.sv
// Module: rpr_decider
// Compares candidate and current ranks and maps the winning rank back to a
// line number. Assumes ranks are in 0..N_LINES with N_LINES meaning none.
module rpr_decider #(
    parameter int N_LINES = 8,
    parameter int IDX_W   = $clog2(N_LINES),
    parameter int RANK_W  = rpr_pkg::rank_width(N_LINES)
) (
    input  logic [RANK_W-1:0] cand_rank,
    input  logic [RANK_W-1:0] cur_rank,
    input  logic [IDX_W-1:0]  offset,
    output logic              win,
    output logic [IDX_W-1:0]  line
);
    localparam logic [IDX_W:0] LIMIT = (IDX_W+1)'(N_LINES);

    logic [IDX_W:0] sum;
    logic [IDX_W:0] wrapped;

    // Strict comparison and rank-to-line mapping.
    always_comb begin
        win     = (cand_rank < cur_rank);
        sum     = (IDX_W+1)'(cand_rank[IDX_W-1:0]) + {1'b0, offset};
        wrapped = (sum >= LIMIT) ? (sum - LIMIT) : sum;
        line    = win ? wrapped[IDX_W-1:0] : '0;
    end
endmodule

// File: rtl/rpr_resolver.sv
// Module: rpr_resolver (top)
// Picks the interrupt line to present: best unmasked request versus best
// in-service line under a rotating priority, with the cascade line left out
// of the in-service side in special fully nested mode on the master.
// Assumes all inputs are settled two-valued levels. Purely combinational.
module rpr_resolver #(
    parameter int N_LINES      = 8,
    parameter int CASCADE_LINE = 2,
    parameter int IDX_W        = $clog2(N_LINES),
    parameter int RANK_W       = rpr_pkg::rank_width(N_LINES)
) (
    input  logic [7:0] req_vec,
    input  logic [7:0] mask_vec,
    input  logic [7:0] isr_vec,
    input  logic [2:0] rot_offset,
    input  logic       sfnm_en,
    input  logic       is_master,
    output logic       irq_valid,
    output logic [2:0] irq_line
);
    logic [N_LINES-1:0] live_req;
    logic [N_LINES-1:0] eff_isr;
    logic [N_LINES-1:0] req_ranked;
    logic [N_LINES-1:0] isr_ranked;
    logic [RANK_W-1:0]  cand_rank;
    logic [RANK_W-1:0]  cur_rank;
    logic               excl_cascade;

    // Unmasked requests and the cascade exclusion condition.
    always_comb begin
        live_req     = req_vec & ~mask_vec;
        excl_cascade = sfnm_en & is_master;
    end

    for (genvar i = 0; i < N_LINES; i++) begin : g_isr
        if (i == CASCADE_LINE) begin : g_casc
            assign eff_isr[i] = isr_vec[i] & ~excl_cascade;
        end else begin : g_plain
            assign eff_isr[i] = isr_vec[i];
        end
    end

    rpr_rotator #(.N_LINES(N_LINES), .IDX_W(IDX_W)) u_rot_req (
        .vec_in(live_req), .offset(rot_offset), .vec_out(req_ranked));
    rpr_rotator #(.N_LINES(N_LINES), .IDX_W(IDX_W)) u_rot_isr (
        .vec_in(eff_isr), .offset(rot_offset), .vec_out(isr_ranked));

    rpr_rank_finder #(.N_LINES(N_LINES), .RANK_W(RANK_W)) u_find_req (
        .ranked(req_ranked), .best_rank(cand_rank));
    rpr_rank_finder #(.N_LINES(N_LINES), .RANK_W(RANK_W)) u_find_isr (
        .ranked(isr_ranked), .best_rank(cur_rank));

    rpr_decider #(.N_LINES(N_LINES), .IDX_W(IDX_W), .RANK_W(RANK_W)) u_dec (
        .cand_rank(cand_rank), .cur_rank(cur_rank), .offset(rot_offset),
        .win(irq_valid), .line(irq_line));

    // Guards on the outputs against the raw inputs.
    always_comb begin
        // R8
        winner_live_chk: assert (!irq_valid || (req_vec[irq_line] && !mask_vec[irq_line]))
            else $error("R8 winner not a live request");
        // R3
        idle_quiet_chk: assert ((live_req != '0) || (!irq_valid && irq_line == '0))
            else $error("R3 output without live request");
        // R4
        empty_isr_fires_chk: assert (!((eff_isr == '0) && (live_req != '0)) || irq_valid)
            else $error("R4 empty service but no output");
        // R5
        no_self_preempt_chk: assert (!irq_valid || !eff_isr[irq_line])
            else $error("R5 winner already in service");
        // R1
        best_rank_chk: assert (!irq_valid ||
                ((req_ranked & ((N_LINES'(1) << cand_rank[IDX_W-1:0]) - N_LINES'(1))) == '0))
            else $error("R1 better ranked request skipped");
    end
endmodule

// File: tb/rpr_resolver_test.sv
// Bench for rpr_resolver: behavioural model compared on every clock.
module rpr_resolver_test;
    localparam time CLK_PERIOD = 10ns;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] req_vec = '0, mask_vec = '0, isr_vec = '0;
    logic [2:0] rot_offset = '0;
    logic       sfnm_en = 1'b0, is_master = 1'b0;
    logic       irq_valid;
    logic [2:0] irq_line;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    rpr_resolver uut (
        .req_vec(req_vec), .mask_vec(mask_vec), .isr_vec(isr_vec),
        .rot_offset(rot_offset), .sfnm_en(sfnm_en), .is_master(is_master),
        .irq_valid(irq_valid), .irq_line(irq_line));

    always #(CLK_PERIOD/2) clk = ~clk;

    // Behavioural expectation straight from the requirements.
    function automatic void model(input logic [7:0] r, m, s, input int off,
                                  input bit sf, ms, output bit v, output int ln);
        int cand = 8;
        int cur  = 8;
        for (int k = 7; k >= 0; k--) begin
            int idx = (k + off) % 8;
            if (r[idx] && !m[idx]) cand = k;
            if (s[idx] && !(sf && ms && idx == 2)) cur = k;
        end
        v  = cand < cur;
        ln = v ? (cand + off) % 8 : 0;
    endfunction

    task automatic apply(input logic [7:0] r, m, s, input int off,
                         input bit sf, ms, input string tag);
        bit ev;
        int el;
        @(posedge clk);
        #1;
        req_vec = r; mask_vec = m; isr_vec = s;
        rot_offset = 3'(off); sfnm_en = sf; is_master = ms;
        @(negedge clk);
        model(r, m, s, off, sf, ms, ev, el);
        checks++;
        if (irq_valid !== ev || irq_line !== 3'(el)) begin
            fails++;
            $display("FAIL %s: got valid=%0b line=%0d, expected valid=%0b line=%0d",
                     tag, irq_valid, irq_line, ev, el);
        end
    endtask

    task automatic expect_out(input bit ev, input int el, input string tag);
        checks++;
        if (irq_valid !== ev || irq_line !== 3'(el)) begin
            fails++;
            $display("FAIL %s: got valid=%0b line=%0d, expected valid=%0b line=%0d",
                     tag, irq_valid, irq_line, ev, el);
        end
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        // R3 reset state: all idle
        @(negedge clk);
        expect_out(1'b0, 0, "R3 idle after reset");

        // R1 offset 0, lines 3 and 5 requested -> 3
        apply(8'h28, 8'h00, 8'h00, 0, 0, 0, "R1 offset0");
        expect_out(1'b1, 3, "R1 offset0 line");
        // R1 offset 4 -> line 5 outranks 3
        apply(8'h28, 8'h00, 8'h00, 4, 0, 0, "R1 offset4");
        expect_out(1'b1, 5, "R8 offset4 line");
        // R2 mask line 5 -> 3 wins
        apply(8'h28, 8'h20, 8'h00, 4, 0, 0, "R2 mask");
        expect_out(1'b1, 3, "R2 masked skipped");
        // R3 all masked
        apply(8'hFF, 8'hFF, 8'h00, 2, 0, 0, "R3 all masked");
        expect_out(1'b0, 0, "R3 idle");
        // R4 empty service, single request on line 7 with offset 0
        apply(8'h80, 8'h00, 8'h00, 0, 0, 0, "R4 empty isr");
        expect_out(1'b1, 7, "R4 fires");
        // R5 equal rank does not preempt
        apply(8'h10, 8'h00, 8'h10, 0, 0, 0, "R5 equal");
        expect_out(1'b0, 0, "R5 equal rank");
        // R5 lower priority request blocked
        apply(8'h40, 8'h00, 8'h10, 0, 0, 0, "R5 lower");
        expect_out(1'b0, 0, "R5 lower rank");
        // R5 higher priority preempts
        apply(8'h02, 8'h00, 8'h10, 0, 0, 0, "R5 higher");
        expect_out(1'b1, 1, "R5 higher rank");
        // R6 master in sfnm: request on line 2 while line 2 in service
        apply(8'h04, 8'h00, 8'h04, 0, 1, 1, "R6 sfnm master");
        expect_out(1'b1, 2, "R6 cascade excluded");
        // R7 same stimulus, non-master, and master without sfnm
        apply(8'h04, 8'h00, 8'h04, 0, 1, 0, "R7 sfnm slave");
        expect_out(1'b0, 0, "R7 slave unaffected");
        apply(8'h04, 8'h00, 8'h04, 0, 0, 1, "R7 master no sfnm");
        expect_out(1'b0, 0, "R7 master no sfnm");
        // R9 extra worse-ranked in-service bits change nothing
        apply(8'h02, 8'h00, 8'hF0, 0, 0, 0, "R9 extra isr");
        expect_out(1'b1, 1, "R9 unchanged");
        // R8 wrap: offset 7, request on line 6 is rank 7
        apply(8'h40, 8'h00, 8'h00, 7, 0, 0, "R8 wrap");
        expect_out(1'b1, 6, "R8 wrap line");

        // R1 R2 R5 R6 R8 random sweep over every offset and flag pair
        for (int off = 0; off < 8; off++) begin
            for (int n = 0; n < 300; n++) begin
                logic [7:0] r, m, s;
                r = 8'($urandom);
                m = 8'($urandom) & 8'($urandom);
                s = 8'($urandom) & 8'($urandom);
                apply(r, m, s, off, 1'($urandom), 1'($urandom), "R1_R5_R8 random");
            end
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule